// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the speed of up to four fans from their tachometer outputs. Each tach input is first brought into the clock domain through two flops, then filtered so that only a level which persists for a set number of clocks is accepted. Rising edges of the filtered level count as pulses. A divided time base of about 90 kHz (one tick every 11.11 us) drives a 16-bit counter per channel. The counter spans a programmable number of consecutive pulses, and the final count is stored as that channel's reading. A slow fan therefore gives a large number, and a stopped fan gives a saturated one.

A host reads each reading as two bytes through a small register port. The low byte must be read first. Reading it freezes the pair that the host sees, so a measurement that lands between the two reads cannot tear the value. After reset every reading is zero until the channel completes its first measurement. This prevents false alarms while fans spin up. The all-ones value 0xFFFF marks a fan that is stalled, failed, absent, or disabled. A per-channel disable input forces that value.

Top module: `fan_tach_meter`

## Requirements
- R1: Each channel counter advances by one on each time-base tick, and a tick occurs once every TICK_DIV clocks.
- R2: A measurement starts on a pulse. It ends on the pulse that completes N pulses in all, which is N-1 tach periods. The tick count over that span becomes the channel's reading, and that same ending pulse starts the next measurement.
- R3: N is taken from the input measPulses. The values 0 and 1 act as 2.
- R4: After reset every channel reads 0x0000 until its first measurement completes or it stalls.
- R5: If a channel counter reaches 0xFFFF before its measurement completes, the reading becomes 0xFFFF. A later complete pulse train replaces it with a valid count.
- R6: While chanDisable of a channel is high, that channel's reading is forced to 0xFFFF from the next clock onward.
- R7: regAddr bit 0 selects the byte (0 = low byte, bits 7:0; 1 = high byte, bits 15:8), and the bits above it select the channel. The byte appears on regRdata on the clock after a cycle with regRead high.
- R8: Reading a channel's low byte freezes the value that channel shows to the host. A following high-byte read of that channel returns the frozen high byte and releases the freeze.
- R9: A tach level change is accepted only after it has persisted for DEB_CYC clocks. Shorter glitches are ignored, and only rising edges of the accepted level count as pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tachIn | input | NUM_CH | Raw tach inputs, one per channel |
| chanDisable | input | NUM_CH | Forces the channel reading to 0xFFFF |
| measPulses | input | PCNT_W | Number of pulses N spanned per measurement |
| regRead | input | 1 | Read strobe for the register port |
| regAddr | input | CH_W+1 | Channel number above a byte select in bit 0 |
| regRdata | output | 8 | Byte read, valid on the clock after regRead |

## Verification
The hardest case to reach from the ports is a stall. The counter must climb through 65535 ticks with no pulse, which is far slower than any useful pulse train. The bench therefore sets the divider to two clocks and simply waits out about 131k cycles. It then shows that a fresh pulse train restores a valid reading. The second hard case is the read freeze. The bench reads a low byte, drives a whole new pulse train with a different period, and only then reads the high byte. This proves the frozen value held while the live reading moved on.

// File: rtl/tach_pkg.sv
package tach_pkg;
  localparam int RESULT_W = 16;

  typedef struct packed {
    logic clrCnt;    // restart counter (loads current tick)
    logic incCnt;    // advance counter by one
    logic latchCnt;  // store counter as reading
    logic latchSat;  // store all ones as reading
  } tachStrobe_t;
endpackage

// File: rtl/tach_chan_ctrl.sv
module tach_chan_ctrl
  import tach_pkg::*;
#(
  parameter int DEB_CYC = 8,
  parameter int PCNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tachPin,
  input  logic              chanDisable,
  input  logic              tick,
  input  logic [PCNT_W-1:0] measPulses,
  input  logic              cntFull,
  output tachStrobe_t       stb
);
  localparam int DEB_W = $clog2(DEB_CYC) + 1;
  localparam logic [DEB_W-1:0] DEB_LAST = DEB_W'(DEB_CYC - 1);

  logic [1:0]        syncQ;
  logic              filtQ;
  logic              filtPrevQ;
  logic [DEB_W-1:0]  debCntQ;
  logic              startedQ, startedD;
  logic [PCNT_W-1:0] seenQ, seenD;
  logic              riseEdge;
  logic [PCNT_W:0]   edgesGoal;

  // two-flop synchroniser and persistence filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= '0;
      filtQ     <= 1'b0;
      filtPrevQ <= 1'b0;
      debCntQ   <= '0;
    end else begin
      syncQ     <= {syncQ[0], tachPin};
      filtPrevQ <= filtQ;
      if (syncQ[1] == filtQ) begin
        debCntQ <= '0;
      end else if (debCntQ == DEB_LAST) begin
        filtQ   <= syncQ[1];
        debCntQ <= '0;
      end else begin
        debCntQ <= debCntQ + 1'b1;
      end
    end
  end

  assign riseEdge  = filtQ & ~filtPrevQ;
  assign edgesGoal = (measPulses < PCNT_W'(2)) ? (PCNT_W+1)'(2) : {1'b0, measPulses};

  always_comb begin
    stb      = '0;
    startedD = startedQ;
    seenD    = seenQ;
    if (chanDisable || cntFull) begin
      stb.latchSat = 1'b1;
      stb.clrCnt   = 1'b1;
      startedD     = 1'b0;
      seenD        = '0;
    end else if (riseEdge) begin
      if (!startedQ) begin
        stb.clrCnt = 1'b1;
        startedD   = 1'b1;
        seenD      = '0;
      end else if (({1'b0, seenQ} + (PCNT_W+1)'(2)) >= edgesGoal) begin
        stb.latchCnt = 1'b1;
        stb.clrCnt   = 1'b1;
        seenD        = '0;
      end else begin
        seenD      = seenQ + 1'b1;
        stb.incCnt = tick;
      end
    end else begin
      stb.incCnt = tick;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startedQ <= 1'b0;
      seenQ    <= '0;
    end else begin
      startedQ <= startedD;
      seenQ    <= seenD;
    end
  end

  AST_DEB_FILTER: assert property (@(posedge clk) disable iff (!rstN)
    (filtQ != $past(filtQ)) |-> ($past(syncQ[1]) == filtQ)); // R9

endmodule

// File: rtl/tach_chan_dpath.sv
module tach_chan_dpath
  import tach_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  tachStrobe_t         stb,
  input  logic                rdLo,
  input  logic                rdHi,
  output logic                cntFull,
  output logic [RESULT_W-1:0] liveOut,
  output logic [RESULT_W-1:0] viewOut
);
  logic [RESULT_W-1:0] cntQ;
  logic [RESULT_W-1:0] resultQ;
  logic [RESULT_W-1:0] heldQ;
  logic                frozenQ;

  assign cntFull = (cntQ == '1);

  // saturating tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (stb.clrCnt) begin
      cntQ <= {{(RESULT_W-1){1'b0}}, tick};
    end else if (stb.incCnt && !cntFull) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  // reading register, zero until first result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
    end else if (stb.latchSat) begin
      resultQ <= '1;
    end else if (stb.latchCnt) begin
      resultQ <= cntQ;
    end
  end

  // host view freeze: low read captures, high read releases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldQ   <= '0;
      frozenQ <= 1'b0;
    end else if (rdHi) begin
      frozenQ <= 1'b0;
    end else if (rdLo && !frozenQ) begin
      heldQ   <= resultQ;
      frozenQ <= 1'b1;
    end
  end

  assign liveOut = resultQ;
  assign viewOut = frozenQ ? heldQ : resultQ;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == '1) |=> ((cntQ == '1) || (cntQ <= RESULT_W'(1)))); // R5

  AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (frozenQ && !rdHi) |=> $stable(viewOut)); // R8

endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
  import tach_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int TICK_DIV = 1111,
  parameter int DEB_CYC  = 8,
  parameter int PCNT_W   = 3,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W  = CH_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] tachIn,
  input  logic [NUM_CH-1:0] chanDisable,
  input  logic [PCNT_W-1:0] measPulses,
  input  logic              regRead,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [7:0]        regRdata
);
  logic                tick;
  logic [CH_W-1:0]     selCh;
  logic                hiSel;
  logic [RESULT_W-1:0] selView;
  logic [RESULT_W-1:0] viewArr [NUM_CH];
  logic [RESULT_W-1:0] liveArr [NUM_CH];

  // time base
  generate
    if (TICK_DIV <= 1) begin : g_tickAlways
      assign tick = 1'b1;
    end else begin : g_tickDiv
      localparam int DIV_W = $clog2(TICK_DIV);
      logic [DIV_W-1:0] divCntQ;
      assign tick = (divCntQ == DIV_W'(TICK_DIV - 1));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)     divCntQ <= '0;
        else if (tick) divCntQ <= '0;
        else           divCntQ <= divCntQ + 1'b1;
      end
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick); // R1
    end
  endgenerate

  assign selCh = regAddr[ADDR_W-1:1];
  assign hiSel = regAddr[0];

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      tachStrobe_t stb;
      logic        cntFull;
      logic        rdLo, rdHi;

      assign rdLo = regRead && !hiSel && (selCh == CH_W'(i));
      assign rdHi = regRead &&  hiSel && (selCh == CH_W'(i));

      tach_chan_ctrl #(.DEB_CYC(DEB_CYC), .PCNT_W(PCNT_W)) u_ctrl (
        .clk(clk), .rstN(rstN), .tachPin(tachIn[i]), .chanDisable(chanDisable[i]),
        .tick(tick), .measPulses(measPulses), .cntFull(cntFull), .stb(stb)
      );

      tach_chan_dpath u_dpath (
        .clk(clk), .rstN(rstN), .tick(tick), .stb(stb), .rdLo(rdLo), .rdHi(rdHi),
        .cntFull(cntFull), .liveOut(liveArr[i]), .viewOut(viewArr[i])
      );

      AST_DISABLE_SAT: assert property (@(posedge clk) disable iff (!rstN)
        chanDisable[i] |=> (liveArr[i] == '1)); // R6
    end
  endgenerate

  always_comb begin
    selView = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (selCh == CH_W'(c)) selView = viewArr[c];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        regRdata <= '0;
    else if (regRead) regRdata <= hiSel ? selView[15:8] : selView[7:0];
  end

endmodule

// File: tb/fan_tach_meter_bench.sv
`timescale 1ns/1ps
module fan_tach_meter_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] tachIn;
  logic [3:0] chanDisable;
  logic [2:0] measPulses;
  logic       regRead;
  logic [2:0] regAddr;
  logic [7:0] regRdata;
  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  fan_tach_meter #(.NUM_CH(4), .TICK_DIV(2), .DEB_CYC(3), .PCNT_W(3)) u_fan_tach_meter (
    .clk(clk), .rstN(rstN), .tachIn(tachIn), .chanDisable(chanDisable),
    .measPulses(measPulses), .regRead(regRead), .regAddr(regAddr), .regRdata(regRdata)
  );

  // {channel, high cycles, low cycles, N, expected ticks}; TICK_DIV=2 halves cycle spans
  localparam logic [63:0] VEC [0:7] = '{
    {8'd0, 16'd10,  16'd10,  8'd2, 16'd10},
    {8'd1, 16'd20,  16'd30,  8'd2, 16'd25},
    {8'd2, 16'd8,   16'd12,  8'd3, 16'd20},
    {8'd3, 16'd300, 16'd300, 8'd4, 16'd900},
    {8'd0, 16'd200, 16'd400, 8'd2, 16'd300},
    {8'd1, 16'd6,   16'd4,   8'd0, 16'd5},
    {8'd2, 16'd6,   16'd6,   8'd7, 16'd36},
    {8'd1, 16'd6,   16'd4,   8'd1, 16'd5}
  };

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic pulses(input int ch, input int hi, input int lo, input int cnt);
    for (int k = 0; k < cnt; k++) begin
      tachIn[ch] = 1'b1;
      repeat (hi) @(negedge clk);
      tachIn[ch] = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  task automatic readByte(input int ch, input logic hi, output logic [7:0] d);
    @(negedge clk);
    regRead = 1'b1;
    regAddr = {2'(ch), hi};
    @(negedge clk);
    regRead = 1'b0;
    d = regRdata;
  endtask

  task automatic readPair(input int ch, input string tag, input int exp);
    logic [7:0] d;
    readByte(ch, 1'b0, d);
    check(tag, d, exp & 8'hFF);
    readByte(ch, 1'b1, d);
    check(tag, d, (exp >> 8) & 8'hFF);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rstN = 1'b0; tachIn = '0; chanDisable = '0; measPulses = 3'd2;
    regRead = 1'b0; regAddr = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R4 R7: all readings zero after reset
    for (int c = 0; c < 4; c++) readPair(c, "R4 R7 reset zero", 0);

    // R1 R2 R3: table of pulse trains
    for (int v = 0; v < 8; v++) begin
      int ch, hi, lo, n, nEff, exp;
      ch = int'(VEC[v][63:56]); hi = int'(VEC[v][55:40]); lo = int'(VEC[v][39:24]);
      n = int'(VEC[v][23:16]); exp = int'(VEC[v][15:0]);
      nEff = (n < 2) ? 2 : n;
      measPulses = 3'(n);
      @(negedge clk);
      pulses(ch, hi, lo, 2 * nEff + 2);
      repeat (4) @(negedge clk);
      readPair(ch, (n < 2) ? "R3 low N acts as 2" : "R1 R2 period count", exp);
    end

    // R8: low read freezes while a new measurement lands
    readByte(0, 1'b0, d);
    check("R8 low before update", d, 8'h2C);
    measPulses = 3'd2;
    pulses(0, 500, 900, 6);
    repeat (4) @(negedge clk);
    readByte(0, 1'b1, d);
    check("R8 frozen high byte", d, 8'h01);
    readPair(0, "R8 released view", 700);

    // R6: disable forces all ones, then pulses restore
    @(negedge clk);
    chanDisable[1] = 1'b1;
    repeat (3) @(negedge clk);
    chanDisable[1] = 1'b0;
    readPair(1, "R6 disabled reads FFFF", 16'hFFFF);
    pulses(1, 20, 30, 6);
    repeat (4) @(negedge clk);
    readPair(1, "R6 recovery after disable", 25);

    // R9: one-cycle glitch inside each low phase is ignored
    measPulses = 3'd2;
    for (int k = 0; k < 6; k++) begin
      tachIn[2] = 1'b1; repeat (10) @(negedge clk);
      tachIn[2] = 1'b0; repeat (5)  @(negedge clk);
      tachIn[2] = 1'b1; @(negedge clk);
      tachIn[2] = 1'b0; repeat (14) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    readPair(2, "R9 glitch ignored", 15);

    // R5: channel 3 idle long enough to saturate, then recovers
    repeat (132000) @(negedge clk);
    readPair(3, "R5 stall saturates", 16'hFFFF);
    pulses(3, 10, 10, 6);
    repeat (4) @(negedge clk);
    readPair(3, "R5 valid after stall", 10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule